// File: doc/BRIEF.md
# Coprocessor Register Store Sequencer

This block places one 64-bit coprocessor register on a 32-bit memory write-data bus while a store instruction runs. The processor offers one beat per cycle. For each beat it gives the instruction word, whether the cycle is a data cycle, the configured byte order and a flag that picks the floating-point or integer form of a one-word store. The block forms a register index from the instruction and reads the two 32-bit halves of that register through an external read port. It drives the selected half onto the bus and answers with one of two responses: "increment", meaning more data follows, or "done".

A long store moves both halves in two beats. The byte-order input sets which half goes first. A short store moves one half in one beat. A one-bit beat counter tracks progress through a long store. Any non-data cycle clears the counter. Address generation, writeback and loads are handled elsewhere.

Top module: `cstore_seq`

## Requirements
- R1: Instruction bit 22 set selects a two-beat (64-bit) store. Bit 22 clear selects a one-beat store.
- R2: A beat offered as a non-data cycle answers "done" and not "increment". It holds `bus_drive` low and `bus_data` at zero, and it clears the beat counter.
- R3: In a two-beat store with `big_endian` high, the first beat carries `rd_upper` and the second carries `rd_lower`.
- R4: In a two-beat store with `big_endian` low, the first beat carries `rd_lower` and the second carries `rd_upper`.
- R5: The first beat of a two-beat store answers "increment" and the second answers "done". After "done", the next two-beat store starts again from its first beat.
- R6: A one-beat store with `as_float` high drives `rd_upper` and answers "done". It leaves the beat counter unchanged.
- R7: A one-beat store with `as_float` low drives `rd_lower` and answers "done".
- R8: `rd_idx` equals instruction bits 15:12 and selects one of 16 registers.
- R9: Reset clears the beat counter. The first two-beat beat after reset is a first beat, even if reset arrived in the middle of a store.
- R10: In a cycle with no beat offered, both responses are low, `bus_drive` is low, `bus_data` is zero and the beat counter holds its value.
- R11: A non-data beat between the two beats of a long store restarts it. The next long-store beat is treated as a first beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| beat_req | input | 1 | A transfer beat is offered this cycle |
| beat_is_data | input | 1 | The offered beat is a data cycle |
| instr | input | 32 | Store instruction word |
| big_endian | input | 1 | Byte-order configuration: 1 selects big-endian |
| as_float | input | 1 | One-beat form: 1 selects floating-point (upper half), 0 selects integer (lower half) |
| rd_idx | output | 4 | Register file read index |
| rd_upper | input | 32 | Upper half of the addressed register |
| rd_lower | input | 32 | Lower half of the addressed register |
| bus_data | output | 32 | Write data for this beat |
| bus_drive | output | 1 | `bus_data` is valid this cycle |
| resp_inc | output | 1 | Response: advance the address, more to come |
| resp_done | output | 1 | Response: transfer complete |

## Verification
The beat counter is the only state in the block, and the ports never show it directly. The difficult cases are the ones where the counter is left in its mid-store state: a one-beat store slipped between two long-store beats, a non-data cycle or reset arriving between the two beats, and idle cycles in the middle of a sequence. The stimulus mixes these kinds of beat at random under a fixed seed, with random byte order, float flag and register contents. Directed sequences place each interruption exactly after a first beat. A bench-side model of the counter predicts which half and which response every beat should produce.

// File: rtl/cstore_pkg.sv
`timescale 1ns/1ps
package cstore_pkg;
   // Response the sequencer gives for one beat.
   typedef enum logic [1:0] {
      RSP_NONE = 2'b00,
      RSP_INC  = 2'b01,
      RSP_DONE = 2'b10
   } cs_rsp_e;

   // Kind of beat, derived at the block edge.
   typedef enum logic [1:0] {
      BEAT_IDLE    = 2'b00,
      BEAT_CTRL    = 2'b01,
      BEAT_NARROW  = 2'b10,
      BEAT_WIDE    = 2'b11
   } cs_beat_e;
endpackage

// File: rtl/cstore_beat_cnt.sv
`timescale 1ns/1ps
module cstore_beat_cnt #(
   parameter int BEATS = 2,
   localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   output logic [CNT_W-1:0] cnt,
   output logic             last
);
   generate
      if (BEATS < 2) begin : g_bad_beats
         $error("cstore_beat_cnt: BEATS must be at least 2");
      end
   endgenerate

   assign last = (cnt == CNT_W'(BEATS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (adv)
         cnt <= last ? '0 : cnt + CNT_W'(1);
   end

   // A non-data cycle leaves the counter at its first beat.
   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

   // After the final beat of a long store the sequence restarts.
   assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr && last) |=> (cnt == '0));

   // With neither clear nor advance, the count holds.
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(cnt));
endmodule

// File: rtl/cstore_half_sel.sv
`timescale 1ns/1ps
module cstore_half_sel #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 1
) (
   input  logic              wide,
   input  logic [CNT_W-1:0]  beat,
   input  logic              big_endian,
   input  logic              as_float,
   input  logic [DATA_W-1:0] upper,
   input  logic [DATA_W-1:0] lower,
   output logic [DATA_W-1:0] word,
   output logic              took_upper
);
   logic beat0;

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("cstore_half_sel: CNT_W must be at least 1");
      end
   endgenerate

   assign beat0 = (beat == '0);

   // Long store: big-endian gives upper first, little-endian gives lower first.
   // Short store: float form lives in the upper half, integer in the lower.
   always_comb begin
      if (wide)
         took_upper = big_endian ? beat0 : !beat0;
      else
         took_upper = as_float;
      word = took_upper ? upper : lower;
   end
endmodule

// File: rtl/cstore_seq.sv
`timescale 1ns/1ps
module cstore_seq #(
   parameter int DATA_W   = 32,
   parameter int INSTR_W  = 32,
   parameter int NREGS    = 16,
   parameter int WIDE_BIT = 22,
   parameter int IDX_LSB  = 12,
   localparam int IDX_W   = $clog2(NREGS),
   localparam int BEATS   = 2,
   localparam int CNT_W   = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               beat_req,
   input  logic               beat_is_data,
   input  logic [INSTR_W-1:0] instr,
   input  logic               big_endian,
   input  logic               as_float,
   output logic [IDX_W-1:0]   rd_idx,
   input  logic [DATA_W-1:0]  rd_upper,
   input  logic [DATA_W-1:0]  rd_lower,
   output logic [DATA_W-1:0]  bus_data,
   output logic               bus_drive,
   output logic               resp_inc,
   output logic               resp_done
);
   import cstore_pkg::*;

   generate
      if (WIDE_BIT >= INSTR_W) begin : g_bad_wide
         $error("cstore_seq: WIDE_BIT outside the instruction");
      end
      if (IDX_LSB + IDX_W > INSTR_W) begin : g_bad_idx
         $error("cstore_seq: register index field outside the instruction");
      end
      if (WIDE_BIT >= IDX_LSB && WIDE_BIT < IDX_LSB + IDX_W) begin : g_overlap
         $error("cstore_seq: width bit overlaps the index field");
      end
      if ((1 << IDX_W) != NREGS) begin : g_bad_nregs
         $error("cstore_seq: NREGS must be a power of two");
      end
   endgenerate

   cs_beat_e            kind;
   cs_rsp_e             rsp;
   logic                wide;
   logic                cnt_clr, cnt_adv, cnt_last;
   logic [CNT_W-1:0]    cnt;
   logic [DATA_W-1:0]   half_word;
   logic                half_upper;

   assign wide   = instr[WIDE_BIT];
   assign rd_idx = instr[IDX_LSB +: IDX_W];

   always_comb begin
      if (!beat_req)          kind = BEAT_IDLE;
      else if (!beat_is_data) kind = BEAT_CTRL;
      else if (wide)          kind = BEAT_WIDE;
      else                    kind = BEAT_NARROW;
   end

   assign cnt_clr = (kind == BEAT_CTRL);
   assign cnt_adv = (kind == BEAT_WIDE);

   cstore_beat_cnt #(.BEATS(BEATS)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (cnt_clr),
      .adv  (cnt_adv),
      .cnt  (cnt),
      .last (cnt_last)
   );

   cstore_half_sel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_sel (
      .wide      (wide),
      .beat      (cnt),
      .big_endian(big_endian),
      .as_float  (as_float),
      .upper     (rd_upper),
      .lower     (rd_lower),
      .word      (half_word),
      .took_upper(half_upper)
   );

   always_comb begin
      unique case (kind)
         BEAT_IDLE:   rsp = RSP_NONE;
         BEAT_WIDE:   rsp = cnt_last ? RSP_DONE : RSP_INC;
         default:     rsp = RSP_DONE;
      endcase
   end

   assign resp_inc  = (rsp == RSP_INC);
   assign resp_done = (rsp == RSP_DONE);
   assign bus_drive = (kind == BEAT_WIDE) || (kind == BEAT_NARROW);
   assign bus_data  = bus_drive ? half_word : '0;

   // Non-data beat: done, nothing driven.
   assert_nondata_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_req && !beat_is_data) |-> (resp_done && !resp_inc && !bus_drive && bus_data == '0));

   // Two responses never at once.
   assert_rsp_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({resp_inc, resp_done}));

   // The beat after an increment, if it continues the long store, finishes it.
   assert_second_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      resp_inc |=> (!(beat_req && beat_is_data && instr[WIDE_BIT]) || resp_done));

   // Long-store responses: increment on the first beat only.
   assert_first_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_req && beat_is_data && instr[WIDE_BIT]) |-> (resp_inc == (cnt == '0)));

   // One-beat store completes at once.
   assert_narrow_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_req && beat_is_data && !instr[WIDE_BIT]) |-> (resp_done && bus_drive));

   // One-beat store picks its half from the float flag.
   assert_narrow_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_req && beat_is_data && !instr[WIDE_BIT]) |-> (half_upper == as_float));

   // Idle cycle is quiet.
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !beat_req |-> (!resp_inc && !resp_done && !bus_drive && bus_data == '0));
endmodule

// File: tb/cstore_seq_tb.sv
`timescale 1ns/1ps
module cstore_seq_tb;
   localparam realtime TCLK = 20ns;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        beat_req = 0, beat_is_data = 0, big_endian = 0, as_float = 0;
   logic [31:0] instr = '0;
   logic [3:0]  rd_idx;
   logic [31:0] rd_upper, rd_lower, bus_data;
   logic        bus_drive, resp_inc, resp_done;

   logic [31:0] mem_up [16];
   logic [31:0] mem_lo [16];

   int n_cmp = 0, n_bad = 0;
   bit mcnt = 0;  // bench model of the beat position

   always #(TCLK/2) clk = ~clk;

   assign rd_upper = mem_up[rd_idx];
   assign rd_lower = mem_lo[rd_idx];

   cstore_seq u_dut (
      .clk(clk), .rst_n(rst_n), .beat_req(beat_req), .beat_is_data(beat_is_data),
      .instr(instr), .big_endian(big_endian), .as_float(as_float), .rd_idx(rd_idx),
      .rd_upper(rd_upper), .rd_lower(rd_lower), .bus_data(bus_data),
      .bus_drive(bus_drive), .resp_inc(resp_inc), .resp_done(resp_done)
   );

   function automatic logic [31:0] mk_instr(input bit wide, input logic [3:0] idx);
      logic [31:0] v;
      v = $urandom;
      v[22] = wide;
      v[15:12] = idx;
      return v;
   endfunction

   function automatic logic [31:0] exp_word(input bit wide, input bit cnt, input bit be,
                                            input bit flt, input logic [3:0] idx);
      bit up;
      if (wide) up = be ? !cnt : cnt;
      else      up = flt;
      return up ? mem_up[idx] : mem_lo[idx];
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // One cycle: drive after the edge, compare mid-cycle, update the model.
   task automatic beat(input bit req, input bit dat, input logic [31:0] ins,
                       input bit be, input bit flt, input string req_tag);
      bit wide, e_inc, e_done, e_drv;
      logic [31:0] e_data;
      @(posedge clk);
      #2;
      beat_req = req; beat_is_data = dat; instr = ins; big_endian = be; as_float = flt;
      #10;
      wide   = ins[22];
      e_drv  = req && dat;
      e_inc  = e_drv && wide && !mcnt;
      e_done = req && !e_inc;
      e_data = e_drv ? exp_word(wide, mcnt, be, flt, ins[15:12]) : 32'h0;
      check({bus_drive, resp_inc, resp_done, bus_data} == {e_drv, e_inc, e_done, e_data},
            req_tag, "drive/inc/done/data",
            {29'h0, bus_drive, resp_inc, resp_done, bus_data},
            {29'h0, e_drv, e_inc, e_done, e_data});
      check(rd_idx == ins[15:12], "R8", "rd_idx", {60'h0, rd_idx}, {60'h0, ins[15:12]});
      if (req && !dat)             mcnt = 0;
      else if (req && dat && wide) mcnt = !mcnt;
   endtask

   task automatic do_reset();
      @(posedge clk); #2;
      rst_n = 0; beat_req = 0;
      mcnt = 0;
      @(posedge clk); #2;
      rst_n = 1;
   endtask

   initial begin : watchdog
      #(TCLK * 200000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'h5EED_0C17));
      for (int i = 0; i < 16; i++) begin
         mem_up[i] = $urandom;
         mem_lo[i] = $urandom;
      end
      #5;
      // Reset state (R9, R10)
      #10;
      check({bus_drive, resp_inc, resp_done} == 3'b000, "R10", "outputs in reset",
            {61'h0, bus_drive, resp_inc, resp_done}, 64'h0);
      @(posedge clk); #2; rst_n = 1;

      // R3: big-endian long store, upper then lower
      beat(1, 1, mk_instr(1, 4'd3), 1, 0, "R3");
      beat(1, 1, mk_instr(1, 4'd3), 1, 0, "R3");
      // R4: little-endian long store, lower then upper; R5 restart after done
      beat(1, 1, mk_instr(1, 4'd9), 0, 0, "R4");
      beat(1, 1, mk_instr(1, 4'd9), 0, 0, "R4");
      beat(1, 1, mk_instr(1, 4'd15), 0, 1, "R5");
      beat(1, 1, mk_instr(1, 4'd15), 0, 1, "R5");
      // R6, R7: one-beat float and integer forms (R1: bit 22 clear)
      beat(1, 1, mk_instr(0, 4'd0), 1, 1, "R6");
      beat(1, 1, mk_instr(0, 4'd0), 0, 0, "R7");
      beat(1, 1, mk_instr(0, 4'd5), 1, 0, "R1");
      // R6: one-beat store mid-sequence leaves the counter alone
      beat(1, 1, mk_instr(1, 4'd6), 1, 0, "R5");
      beat(1, 1, mk_instr(0, 4'd6), 1, 1, "R6");
      beat(1, 1, mk_instr(1, 4'd6), 1, 0, "R6");
      // R11: non-data cycle mid-sequence restarts it; R2 on the cycle itself
      beat(1, 1, mk_instr(1, 4'd7), 0, 0, "R4");
      beat(1, 0, mk_instr(1, 4'd7), 0, 0, "R2");
      beat(1, 1, mk_instr(1, 4'd7), 0, 0, "R11");
      beat(1, 1, mk_instr(1, 4'd7), 0, 0, "R11");
      // R10: idle mid-sequence holds the counter
      beat(1, 1, mk_instr(1, 4'd2), 1, 0, "R3");
      beat(0, 1, mk_instr(1, 4'd2), 1, 0, "R10");
      beat(1, 1, mk_instr(1, 4'd2), 1, 0, "R10");
      // R9: reset in the middle of a long store
      beat(1, 1, mk_instr(1, 4'd11), 1, 0, "R3");
      do_reset();
      beat(1, 1, mk_instr(1, 4'd11), 1, 0, "R9");
      beat(1, 1, mk_instr(1, 4'd11), 1, 0, "R9");

      // Constrained random mix
      for (int i = 0; i < 600; i++) begin
         int  sel;
         bit  rq, dt;
         sel = $urandom_range(0, 9);
         rq  = (sel != 0);
         dt  = (sel > 1);
         if (i % 50 == 0) begin
            mem_up[$urandom_range(0, 15)] = $urandom;
            mem_lo[$urandom_range(0, 15)] = $urandom;
         end
         beat(rq, dt, mk_instr($urandom_range(0, 3) != 0, 4'($urandom_range(0, 15))),
              1'($urandom), 1'($urandom), "R1");
      end

      @(posedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule